// File: doc/BRIEF.md
# Bus-Master DMA Register Port

This block is the byte-wide register window for the two bus-master DMA channels of a disk controller. A host-side I/O access arrives with an address inside a 16-byte window, a size code and, for writes, a data byte. The lower half of the window belongs to channel 0 and the upper half to channel 1. In each half, the low four bytes hold the channel's command, the mode register shared by both channels, the channel's status and the channel's timing byte. The high four bytes of each half hold a descriptor pointer that lives elsewhere, so this block does not decode them.

The block applies each register's write rule. The command byte is stored, and a strobe goes to the DMA engine. The status byte mixes freely writable flags, write-one-to-clear flags and an engine-owned activity bit. The shared mode register accepts writes only to its two interrupt-block bits. The DMA engine sets status bits through dedicated inputs. The interrupt-mirroring logic gets a pulse whenever the block bits are written, so it can recompute its output. Reads are combinational and return the selected byte zero-extended on a 32-bit read bus.

Top module: `bmw_port`

## Requirements
- R1: Channel 0 registers decode at offsets 0-3 and channel 1 registers at offsets 8-11, with offset 0 = command, 1 = mode, 2 = status, 3 = timing within each channel. A read of any offset in 4-7 or 12-15 returns 0xFFFFFFFF.
- R2: `acc_size` 0 means a byte access, and any other code is a wider access. A wider read returns 0xFFFFFFFF, and a wider write changes no register. A byte read returns the register in bits 7:0 with bits 31:8 zero.
- R3: A byte write to offset 0 of a channel stores the byte as that channel's command. In the next cycle that channel's `cmd_wr` bit is high for exactly one cycle, and `chan_cmd` shows the new byte.
- R4: The mode register reads the same at offset 1 of either channel. Bits 3:2 show `chan_irq[1:0]` delayed by one cycle, bits 5:4 are block bits (bit 4 for channel 0, bit 5 for channel 1), and bits 7:6 and 1:0 read zero. A byte write at offset 1 changes only bits 5:4.
- R5: One cycle after any byte write to offset 1 of either channel, `mask_upd` is high for exactly one cycle.
- R6: A byte write to a status register takes bits 6:5 from the data and clears bit 1 or bit 2 where the data bit is 1. It leaves bit 0 unchanged. Bits 7, 4 and 3 always read zero.
- R7: Status bit 0 shows the channel's `dma_active` input delayed by one cycle, whatever software writes.
- R8: `dma_err_set` sets status bit 1 and `dma_irq_set` sets status bit 2. A set in the same cycle as a software clear of that bit leaves the bit set.
- R9: Each channel has its own full 8-bit timing register at offset 3. A write to one channel's timing register does not change the other's.
- R10: Reset clears command, status, timing, the mode block bits and the mirrored interrupt bits to zero, and holds `cmd_wr` and `mask_upd` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 = byte, otherwise wider access |
| acc_addr | input | 4 | Byte offset inside the window |
| acc_wdata | input | 8 | Write data byte |
| acc_rdata | output | 32 | Combinational read data |
| dma_active | input | 2 | Per-channel engine activity level |
| dma_err_set | input | 2 | Per-channel error set request |
| dma_irq_set | input | 2 | Per-channel interrupt set request |
| chan_irq | input | 2 | Per-channel interrupt level from the mirroring logic |
| cmd_wr | output | 2 | Per-channel command write strobe |
| chan_cmd | output | 16 | Command bytes, channel 0 in bits 7:0 |
| chan_status | output | 16 | Status bytes, channel 0 in bits 7:0 |
| chan_timing | output | 16 | Timing bytes, channel 0 in bits 7:0 |
| mode_val | output | 8 | Shared mode register |
| mask_upd | output | 1 | Pulse after a block-bit write |

## Verification
The bench targets the status byte's mixed write rule. A design that treats the byte as plain storage would let software set the error and interrupt flags or clear the activity bit. A design that gets the set/clear priority backwards would lose an error flag that the engine raises in the same cycle software clears it.

The bench reads the mode register through both channel aliases. A missing alias or a loose write mask would show up as bits written through one offset being absent at the other, or as the mirrored interrupt bits being overwritten.

The bench also checks wide accesses and the pointer offsets. Decoding those would either return register contents instead of all ones, or corrupt the timing byte on a 32-bit write.

The bench also times the command and block-bit strobes to the cycle, and checks that a timing write to one channel leaves the other channel's timing byte alone.

// File: rtl/bmw_pkg.sv
package bmw_pkg;
    localparam int NUM_CH  = 2;
    localparam int BYTE_W  = 8;
    localparam int RDATA_W = 32;

    typedef enum logic [1:0] {
        REG_CMD  = 2'd0,
        REG_MODE = 2'd1,
        REG_STAT = 2'd2,
        REG_TIM  = 2'd3
    } reg_sel_e;

    localparam logic [BYTE_W-1:0] STAT_DIRECT_M = 8'h60;
    localparam logic [BYTE_W-1:0] STAT_W1C_M    = 8'h06;
    localparam logic [BYTE_W-1:0] STAT_KEEP_M   = 8'h01;
    localparam logic [BYTE_W-1:0] STAT_IMPL_M   = STAT_DIRECT_M | STAT_W1C_M | STAT_KEEP_M;
    localparam int STAT_ACT = 0;
    localparam int STAT_ERR = 1;
    localparam int STAT_IRQ = 2;
    localparam int MODE_IRQ_LSB  = 2;
    localparam int MODE_MASK_LSB = 4;

    typedef struct packed {
        logic [BYTE_W-1:0] cmd;
        logic [BYTE_W-1:0] stat;
        logic [BYTE_W-1:0] tim;
        logic              strobe;
    } chan_state_t;

    typedef struct packed {
        logic [NUM_CH-1:0] mask;
        logic [NUM_CH-1:0] irq;
        logic              pulse;
    } mode_state_t;
endpackage

// File: rtl/bmw_decode.sv
module bmw_decode
    import bmw_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic [1:0]          acc_size,
    input  logic [ADDR_W-1:0]   acc_addr,
    output logic                rd_hit,
    output logic [ADDR_W-4:0]   rd_ch,
    output reg_sel_e            rd_reg,
    output logic [NUM_CH-1:0]   wr_cmd,
    output logic [NUM_CH-1:0]   wr_stat,
    output logic [NUM_CH-1:0]   wr_tim,
    output logic                wr_mode
);
    localparam int CH_W = ADDR_W - 3;

    logic byte_hit;
    logic wr_hit;

    assign rd_ch    = acc_addr[ADDR_W-1:3];
    assign rd_reg   = reg_sel_e'(acc_addr[1:0]);
    assign byte_hit = acc_valid && (acc_size == 2'd0) && !acc_addr[2]
                      && (int'(rd_ch) < NUM_CH);
    assign rd_hit   = byte_hit;
    assign wr_hit   = byte_hit && acc_write;
    assign wr_mode  = wr_hit && (rd_reg == REG_MODE);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel;
        assign sel        = wr_hit && (rd_ch == CH_W'(c));
        assign wr_cmd[c]  = sel && (rd_reg == REG_CMD);
        assign wr_stat[c] = sel && (rd_reg == REG_STAT);
        assign wr_tim[c]  = sel && (rd_reg == REG_TIM);
    end

    // R2: a wider access never reaches any register
    always_comb begin
        if (acc_size != 2'd0) begin
            assert_wide_no_we_R2: assert ((wr_cmd | wr_stat | wr_tim) == '0 && !wr_mode);
        end
    end
endmodule

// File: rtl/bmw_chan.sv
module bmw_chan
    import bmw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic              wr_stat,
    input  logic              wr_tim,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              busy,
    input  logic              err_set,
    input  logic              irq_set,
    output logic [BYTE_W-1:0] cmd_q,
    output logic [BYTE_W-1:0] stat_q,
    output logic [BYTE_W-1:0] tim_q,
    output logic              strobe_q
);
    chan_state_t st_d, st_q;

    always_comb begin
        logic [BYTE_W-1:0] s;
        st_d        = st_q;
        st_d.strobe = wr_cmd;
        if (wr_cmd) st_d.cmd = wdata;
        if (wr_tim) st_d.tim = wdata;
        s = st_q.stat;
        if (wr_stat) begin
            s = (wdata & STAT_DIRECT_M) | (s & STAT_KEEP_M) | (s & ~wdata & STAT_W1C_M);
        end
        s[STAT_ACT] = busy;
        s[STAT_ERR] = s[STAT_ERR] | err_set;
        s[STAT_IRQ] = s[STAT_IRQ] | irq_set;
        st_d.stat   = s & STAT_IMPL_M;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_q    = st_q.cmd;
    assign stat_q   = st_q.stat;
    assign tim_q    = st_q.tim;
    assign strobe_q = st_q.strobe;

    assert_stat_rsvd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q & ~STAT_IMPL_M) == '0);
    assert_err_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |=> stat_q[STAT_ERR]);
    assert_irq_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> stat_q[STAT_IRQ]);
    assert_active_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> stat_q[STAT_ACT]);
    assert_tim_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_tim |=> $stable(tim_q));
    assert_cmd_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd |=> strobe_q && cmd_q == $past(wdata));
endmodule

// File: rtl/bmw_mode.sv
module bmw_mode
    import bmw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_mode,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [NUM_CH-1:0] irq_lvl,
    output logic [BYTE_W-1:0] mode_q,
    output logic              pulse_q
);
    mode_state_t md_d, md_q;

    always_comb begin
        md_d       = md_q;
        md_d.irq   = irq_lvl;
        md_d.pulse = wr_mode;
        if (wr_mode) md_d.mask = wdata[MODE_MASK_LSB +: NUM_CH];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) md_q <= '0;
        else        md_q <= md_d;
    end

    always_comb begin
        mode_q = '0;
        mode_q[MODE_IRQ_LSB  +: NUM_CH] = md_q.irq;
        mode_q[MODE_MASK_LSB +: NUM_CH] = md_q.mask;
    end
    assign pulse_q = md_q.pulse;

    assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mode |=> $stable(mode_q[MODE_MASK_LSB +: NUM_CH]));
    assert_mask_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode |=> pulse_q);
    assert_no_spurious_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mode |=> !pulse_q);
endmodule

// File: rtl/bmw_port.sv
module bmw_port
    import bmw_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      acc_valid,
    input  logic                      acc_write,
    input  logic [1:0]                acc_size,
    input  logic [ADDR_W-1:0]         acc_addr,
    input  logic [BYTE_W-1:0]         acc_wdata,
    output logic [RDATA_W-1:0]        acc_rdata,
    input  logic [NUM_CH-1:0]         dma_active,
    input  logic [NUM_CH-1:0]         dma_err_set,
    input  logic [NUM_CH-1:0]         dma_irq_set,
    input  logic [NUM_CH-1:0]         chan_irq,
    output logic [NUM_CH-1:0]         cmd_wr,
    output logic [NUM_CH*BYTE_W-1:0]  chan_cmd,
    output logic [NUM_CH*BYTE_W-1:0]  chan_status,
    output logic [NUM_CH*BYTE_W-1:0]  chan_timing,
    output logic [BYTE_W-1:0]         mode_val,
    output logic                      mask_upd
);
    localparam int CH_W = ADDR_W - 3;

    logic              rd_hit;
    logic [CH_W-1:0]   rd_ch;
    reg_sel_e          rd_reg;
    logic [NUM_CH-1:0] wr_cmd, wr_stat, wr_tim;
    logic              wr_mode;
    logic [BYTE_W-1:0] cmd_a  [NUM_CH];
    logic [BYTE_W-1:0] stat_a [NUM_CH];
    logic [BYTE_W-1:0] tim_a  [NUM_CH];

    bmw_decode #(.ADDR_W(ADDR_W)) u_decode (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_size  (acc_size),
        .acc_addr  (acc_addr),
        .rd_hit    (rd_hit),
        .rd_ch     (rd_ch),
        .rd_reg    (rd_reg),
        .wr_cmd    (wr_cmd),
        .wr_stat   (wr_stat),
        .wr_tim    (wr_tim),
        .wr_mode   (wr_mode)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        bmw_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_cmd   (wr_cmd[c]),
            .wr_stat  (wr_stat[c]),
            .wr_tim   (wr_tim[c]),
            .wdata    (acc_wdata),
            .busy     (dma_active[c]),
            .err_set  (dma_err_set[c]),
            .irq_set  (dma_irq_set[c]),
            .cmd_q    (cmd_a[c]),
            .stat_q   (stat_a[c]),
            .tim_q    (tim_a[c]),
            .strobe_q (cmd_wr[c])
        );
        assign chan_cmd[c*BYTE_W +: BYTE_W]    = cmd_a[c];
        assign chan_status[c*BYTE_W +: BYTE_W] = stat_a[c];
        assign chan_timing[c*BYTE_W +: BYTE_W] = tim_a[c];
    end

    bmw_mode u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mode (wr_mode),
        .wdata   (acc_wdata),
        .irq_lvl (chan_irq),
        .mode_q  (mode_val),
        .pulse_q (mask_upd)
    );

    always_comb begin
        acc_rdata = '1;
        if (rd_hit) begin
            acc_rdata = '0;
            unique case (rd_reg)
                REG_CMD:  acc_rdata[BYTE_W-1:0] = cmd_a[rd_ch];
                REG_MODE: acc_rdata[BYTE_W-1:0] = mode_val;
                REG_STAT: acc_rdata[BYTE_W-1:0] = stat_a[rd_ch];
                REG_TIM:  acc_rdata[BYTE_W-1:0] = tim_a[rd_ch];
            endcase
        end
    end

    assert_cmd_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_wr));
    assert_wide_read_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_size != 2'd0) |-> acc_rdata == '1);
endmodule

// File: tb/test_bmw_port.sv
`timescale 1ns/1ps
module test_bmw_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [1:0]  acc_size = 2'd0;
    logic [3:0]  acc_addr = 4'd0;
    logic [7:0]  acc_wdata = 8'd0;
    logic [31:0] acc_rdata;
    logic [1:0]  dma_active = 2'b00, dma_err_set = 2'b00, dma_irq_set = 2'b00, chan_irq = 2'b00;
    logic [1:0]  cmd_wr;
    logic [15:0] chan_cmd, chan_status, chan_timing;
    logic [7:0]  mode_val;
    logic        mask_upd;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    bmw_port i_bmw_port (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_size(acc_size), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .dma_active(dma_active), .dma_err_set(dma_err_set),
        .dma_irq_set(dma_irq_set), .chan_irq(chan_irq), .cmd_wr(cmd_wr),
        .chan_cmd(chan_cmd), .chan_status(chan_status), .chan_timing(chan_timing),
        .mode_val(mode_val), .mask_upd(mask_upd)
    );

    // {req, write, size, addr, wdata, expected read}
    localparam int NV = 25;
    localparam logic [50:0] VEC [NV] = '{
        {4'd10, 1'b0, 2'd0, 4'h0, 8'h00, 32'h0000_0000}, // R10 command clear
        {4'd9,  1'b1, 2'd0, 4'h3, 8'hA5, 32'h0},         // R9
        {4'd9,  1'b0, 2'd0, 4'h3, 8'h00, 32'h0000_00A5}, // R9
        {4'd9,  1'b1, 2'd0, 4'hB, 8'h3C, 32'h0},         // R9
        {4'd9,  1'b0, 2'd0, 4'hB, 8'h00, 32'h0000_003C}, // R9
        {4'd9,  1'b0, 2'd0, 4'h3, 8'h00, 32'h0000_00A5}, // R9 independent
        {4'd6,  1'b1, 2'd0, 4'h2, 8'hFF, 32'h0},         // R6
        {4'd6,  1'b0, 2'd0, 4'h2, 8'h00, 32'h0000_0060}, // R6
        {4'd6,  1'b0, 2'd0, 4'hA, 8'h00, 32'h0000_0000}, // R6 other channel
        {4'd6,  1'b1, 2'd0, 4'h2, 8'h00, 32'h0},         // R6
        {4'd6,  1'b0, 2'd0, 4'h2, 8'h00, 32'h0000_0000}, // R6
        {4'd4,  1'b1, 2'd0, 4'h1, 8'hFF, 32'h0},         // R4
        {4'd4,  1'b0, 2'd0, 4'h9, 8'h00, 32'h0000_0030}, // R4 alias
        {4'd4,  1'b1, 2'd0, 4'h9, 8'h0F, 32'h0},         // R4
        {4'd4,  1'b0, 2'd0, 4'h1, 8'h00, 32'h0000_0000}, // R4
        {4'd2,  1'b1, 2'd1, 4'h8, 8'h77, 32'h0},         // R2 wide write
        {4'd2,  1'b0, 2'd0, 4'h8, 8'h00, 32'h0000_0000}, // R2
        {4'd2,  1'b0, 2'd2, 4'h8, 8'h00, 32'hFFFF_FFFF}, // R2 wide read
        {4'd1,  1'b0, 2'd0, 4'h4, 8'h00, 32'hFFFF_FFFF}, // R1 pointer offset
        {4'd1,  1'b0, 2'd0, 4'hC, 8'h00, 32'hFFFF_FFFF}, // R1 pointer offset
        {4'd2,  1'b1, 2'd2, 4'h3, 8'h11, 32'h0},         // R2 wide write
        {4'd2,  1'b0, 2'd0, 4'h3, 8'h00, 32'h0000_00A5}, // R2
        {4'd3,  1'b1, 2'd0, 4'h0, 8'hC1, 32'h0},         // R3
        {4'd3,  1'b0, 2'd0, 4'h0, 8'h00, 32'h0000_00C1}, // R3
        {4'd3,  1'b0, 2'd0, 4'h8, 8'h00, 32'h0000_0000}  // R3 other channel
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(logic wr, logic [1:0] sz, logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_size = sz; acc_addr = a; acc_wdata = d;
    endtask

    task automatic step_idle();
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_size = 2'd0;
        dma_err_set = 2'b00; dma_irq_set = 2'b00;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 cmd",    {30'd0, cmd_wr},      32'd0);
        check("R10 status", {16'd0, chan_status}, 32'd0);
        check("R10 timing", {16'd0, chan_timing}, 32'd0);
        check("R10 mode",   {23'd0, mask_upd, mode_val}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][46], VEC[i][45:44], VEC[i][43:40], VEC[i][39:32]);
            #1;
            if (!VEC[i][46])
                check($sformatf("R%0d vec %0d", VEC[i][50:47], i), acc_rdata, VEC[i][31:0]);
        end
        step_idle();

        // R3 strobe timing
        drive(1'b1, 2'd0, 4'h8, 8'h5A);
        step_idle();
        check("R3 strobe", {30'd0, cmd_wr}, 32'd2);
        check("R3 cmd value", {24'd0, chan_cmd[15:8]}, 32'h5A);
        step_idle();
        check("R3 strobe one cycle", {30'd0, cmd_wr}, 32'd0);

        // R8 hardware set, then set beats simultaneous clear
        @(negedge clk); dma_err_set = 2'b10;
        step_idle();
        check("R8 err set", {24'd0, chan_status[15:8]}, 32'h02);
        drive(1'b1, 2'd0, 4'hA, 8'h06); dma_irq_set = 2'b10;
        step_idle();
        check("R8 set wins over clear", {24'd0, chan_status[15:8]}, 32'h04);
        drive(1'b1, 2'd0, 4'hA, 8'h04);
        step_idle();
        check("R6 w1c irq", {24'd0, chan_status[15:8]}, 32'h00);

        // R7 active bit follows engine, not software
        @(negedge clk); dma_active = 2'b01;
        @(negedge clk);
        check("R7 active set", {24'd0, chan_status[7:0]}, 32'h01);
        drive(1'b1, 2'd0, 4'h2, 8'h00);
        step_idle();
        check("R7 sw write keeps active", {24'd0, chan_status[7:0]}, 32'h01);
        dma_active = 2'b00;
        @(negedge clk);
        check("R7 active clear", {24'd0, chan_status[7:0]}, 32'h00);

        // R4 mirrored interrupt bits, R5 mask pulse
        chan_irq = 2'b10;
        @(negedge clk);
        check("R4 irq mirror", {24'd0, mode_val}, 32'h08);
        check("R5 no pulse idle", {31'd0, mask_upd}, 32'd0);
        drive(1'b1, 2'd0, 4'h9, 8'h10);
        step_idle();
        check("R5 mask pulse", {31'd0, mask_upd}, 32'd1);
        check("R4 mask bit ch0", {24'd0, mode_val}, 32'h18);
        step_idle();
        check("R5 pulse one cycle", {31'd0, mask_upd}, 32'd0);

        // R10 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R10 timing cleared", {16'd0, chan_timing}, 32'd0);
        check("R10 cmd cleared", {16'd0, chan_cmd}, 32'd0);
        check("R10 mode cleared", {24'd0, mode_val}, 32'd0);
        rst_n = 1'b1; chan_irq = 2'b00;
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule